// File: doc/BRIEF.md
# Branch Condition and Loop Repeat Unit

This unit decides, in the same cycle the request arrives, whether a branch is taken. It supports three condition sources. The first tests a stored four-bit condition-code register. The second compares two register operands directly as signed numbers. The third tests one register against zero. The condition-code register is written only when an ALU result arrives with its write enable. The other two sources neither read nor disturb it.

Beside the branch logic sits a hardware repeat counter. A repeat command loads a pass count, and the fetch stage signals each time it reaches the end marker of the loop body. The unit answers every marker with a loop-back request while further passes remain. After the last pass it lets execution fall through and returns to idle. A count of zero asks fetch to skip the body.

Top module: `bcu_top`

## Requirements
- R1: The flag register holds four bits ordered {Z,N,V,C}: Z at bit 3, N at bit 2, V at bit 1, C at bit 0. It resets to zero and takes `flag_in` at a clock edge where `flag_we` is high. It is visible on `flags`.
- R2: At an edge where `flag_we` is low, `flags` keeps its value, whatever branch requests are presented.
- R3: With `br_src`=0 (flags), relation codes are EQ=0, NE=1, LT=2, GE=3, GT=4 and LE=5. The conditions are: EQ is Z, NE is not Z, LT is N xor V, GE is its complement, GT is (not Z) and GE, and LE is the complement of GT.
- R4: With `br_src`=1 (compare), the same six relations are evaluated on `opa` against `opb`, both taken as two's-complement signed values, and the flags play no part.
- R5: With `br_src`=2 (zero test), EQ is taken when `opa` is zero and NE when it is non-zero. Relation codes 2 to 7 are never taken, and nothing is taken with `br_src`=3 or with relation codes 6 and 7.
- R6: `br_taken` is combinational from the current inputs and flags, and it is low whenever `br_valid` is low.
- R7: After `rpt_load` with a count N≥1, the first N-1 assertions of `loop_end` each raise `loop_back` in that cycle, and the Nth does not.
- R8: After the final pass the counter is zero and `rpt_active` is low. A `loop_end` while the counter is idle never raises `loop_back`.
- R9: `rpt_load` with a count of zero raises `rpt_skip` in that cycle and leaves `rpt_active` low afterwards.
- R10: When `rpt_load` and `loop_end` arrive in the same cycle, the load wins: no loop-back is requested and the new count starts afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_we | input | 1 | Write enable for the flag register |
| flag_in | input | 4 | New flags {Z,N,V,C} from the ALU |
| br_valid | input | 1 | Branch request present |
| br_src | input | 2 | Condition source: 0 flags, 1 compare, 2 zero test |
| br_rel | input | 3 | Relation code |
| opa | input | WIDTH | First register operand |
| opb | input | WIDTH | Second register operand |
| rpt_load | input | 1 | Load the repeat count |
| rpt_count | input | CNT_W | Number of loop passes |
| loop_end | input | 1 | Fetch reached the loop end marker |
| flags | output | 4 | Current flag register |
| br_taken | output | 1 | Branch condition holds |
| loop_back | output | 1 | Request fetch to return to the loop start |
| rpt_skip | output | 1 | Request fetch to skip the loop body |
| rpt_active | output | 1 | Repeat counter is non-zero |

## Verification
On every cycle the assertions check that the flags change only through a write, that a write lands exactly, and that each marker steps the repeat counter down by one or clears it on the last pass. They also check that a zero-count load leaves the counter idle. The truth of each relation can only be shown by the bench scenarios. These sweep every flag pattern, signed operand pairs that include the extremes, the zero test, and repeat counts from zero upward, including a reload in mid-loop. Those scenarios also establish the pass count seen at the ports and the priority of load over marker.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    typedef enum logic [1:0] {
        SRC_FLAGS = 2'd0,
        SRC_CMP   = 2'd1,
        SRC_ZERO  = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_GE = 3'd3,
        REL_GT = 3'd4,
        REL_LE = 3'd5,
        REL_X6 = 3'd6,
        REL_X7 = 3'd7
    } rel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } cc_t;

    function automatic logic rel_pick(input rel_e rel, input logic eq, input logic lt);
        logic r;
        case (rel)
            REL_EQ:  r = eq;
            REL_NE:  r = !eq;
            REL_LT:  r = lt;
            REL_GE:  r = !lt;
            REL_GT:  r = !eq && !lt;
            REL_LE:  r = eq || lt;
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bcu_flags.sv
module bcu_flags
    import bcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cc_t  wdata,
    output cc_t  cc
);
    typedef struct packed {
        cc_t cc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cc = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cc = st_q.cc;

    // R2: without a write the condition codes stay put
    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> $stable(cc));

    // R1: a write lands exactly on the next cycle
    a_r1_flags_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cc == $past(wdata)));
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  src_e             src,
    input  rel_e             rel,
    input  cc_t              cc,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             cond
);
    logic cmp_eq;
    logic cmp_lt;
    logic zr_eq;
    logic cc_lt;

    always_comb begin
        cmp_eq = (opa == opb);
        cmp_lt = ($signed(opa) < $signed(opb));
        zr_eq  = (opa == '0);
        cc_lt  = cc.n ^ cc.v;
        case (src)
            SRC_FLAGS: cond = rel_pick(rel, cc.z, cc_lt);
            SRC_CMP:   cond = rel_pick(rel, cmp_eq, cmp_lt);
            SRC_ZERO:  cond = (rel == REL_EQ) ? zr_eq :
                              (rel == REL_NE) ? !zr_eq : 1'b0;
            default:   cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_repeat.sv
module bcu_repeat #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             marker,
    output logic             back,
    output logic             skip,
    output logic             active
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic more;

    always_comb begin
        st_d = st_q;
        more = (st_q.cnt > ONE);
        back = 1'b0;
        skip = 1'b0;
        if (load) begin
            st_d.cnt = count;
            skip     = (count == '0);
        end else if (marker && st_q.cnt != '0) begin
            back     = more;
            st_d.cnt = more ? (st_q.cnt - ONE) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);

    // R7: each marker with passes left steps the count down by one
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (marker && !load && st_q.cnt > ONE) |=> (st_q.cnt == $past(st_q.cnt) - ONE));

    // R8: the last pass clears the counter
    a_r8_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (marker && !load && st_q.cnt == ONE) |=> !active);

    // R9: a zero count never starts a loop
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load && count == '0) |=> !active);

    // R10: a load wins over a marker in the same cycle
    a_r10_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && marker) |=> (st_q.cnt == $past(count)));
endmodule

// File: rtl/bcu_top.sv
module bcu_top
    import bcu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we,
    input  logic [3:0]       flag_in,
    input  logic             br_valid,
    input  logic [1:0]       br_src,
    input  logic [2:0]       br_rel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             rpt_load,
    input  logic [CNT_W-1:0] rpt_count,
    input  logic             loop_end,
    output logic [3:0]       flags,
    output logic             br_taken,
    output logic             loop_back,
    output logic             rpt_skip,
    output logic             rpt_active
);
    cc_t  cc;
    logic cond;

    bcu_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .wdata (cc_t'(flag_in)),
        .cc    (cc)
    );

    bcu_cond_eval #(.WIDTH(WIDTH)) u_eval (
        .src  (src_e'(br_src)),
        .rel  (rel_e'(br_rel)),
        .cc   (cc),
        .opa  (opa),
        .opb  (opb),
        .cond (cond)
    );

    bcu_repeat #(.CNT_W(CNT_W)) u_rpt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rpt_load),
        .count  (rpt_count),
        .marker (loop_end),
        .back   (loop_back),
        .skip   (rpt_skip),
        .active (rpt_active)
    );

    assign flags    = cc;
    assign br_taken = br_valid && cond;

    // R8: no loop-back request without an armed counter
    a_r8_back_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |-> rpt_active);

    // R4: a compare-mode branch leaves the flags alone
    a_r4_cmp_no_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_src == 2'd1 && !flag_we) |=> $stable(flags));
endmodule

// File: tb/tb_bcu_top.sv
module tb_bcu_top;
    localparam int W  = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag_we = 1'b0;
    logic [3:0]    flag_in = '0;
    logic          br_valid = 1'b0;
    logic [1:0]    br_src = '0;
    logic [2:0]    br_rel = '0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic          rpt_load = 1'b0;
    logic [CW-1:0] rpt_count = '0;
    logic          loop_end = 1'b0;
    logic [3:0]    flags;
    logic          br_taken;
    logic          loop_back;
    logic          rpt_skip;
    logic          rpt_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bcu_top #(.WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
        .br_valid(br_valid), .br_src(br_src), .br_rel(br_rel),
        .opa(opa), .opb(opb), .rpt_load(rpt_load), .rpt_count(rpt_count),
        .loop_end(loop_end), .flags(flags), .br_taken(br_taken),
        .loop_back(loop_back), .rpt_skip(rpt_skip), .rpt_active(rpt_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rel_exp(input int rel, input bit eq, input bit lt);
        case (rel)
            0: return int'(eq);
            1: return int'(!eq);
            2: return int'(lt);
            3: return int'(!lt);
            4: return int'(!eq && !lt);
            5: return int'(eq || lt);
            default: return 0;
        endcase
    endfunction

    function automatic logic [W-1:0] pick(input int i);
        case (i)
            0: return 16'h8000;
            1: return 16'hFFFF;
            2: return 16'h0000;
            3: return 16'h0001;
            4: return 16'h7FFF;
            default: return 16'h0005;
        endcase
    endfunction

    task automatic write_flags(input logic [3:0] f);
        @(negedge clk);
        flag_we = 1'b1;
        flag_in = f;
        @(negedge clk);
        flag_we = 1'b0;
        flag_in = ~f;
    endtask

    task automatic branch(input int src, input int rel, input logic [W-1:0] a,
                          input logic [W-1:0] b, input string req, input int exp);
        @(negedge clk);
        br_valid = 1'b1;
        br_src   = 2'(src);
        br_rel   = 3'(rel);
        opa      = a;
        opb      = b;
        #1;
        chk(req, int'(br_taken), exp);
    endtask

    // runs markers until fall-through, checking each against N
    task automatic run_loop(input int n, input string req, output int passes);
        bit lb;
        passes = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            loop_end = 1'b1;
            #1;
            lb = loop_back;
            passes++;
            chk(req, int'(lb), int'(passes < n));
            @(negedge clk);
            loop_end = 1'b0;
            if (!lb) break;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", int'(flags), 0);
        chk("R8 reset idle", int'(rpt_active), 0);
        chk("R6 idle not taken", int'(br_taken), 0);

        // R1, R3: every flag pattern against every relation
        for (int f = 0; f < 16; f++) begin
            write_flags(4'(f));
            chk("R1 flag write", int'(flags), f);
            for (int r = 0; r < 8; r++) begin
                branch(0, r, '0, '0, "R3 flag relation",
                       rel_exp(r, f[3], f[2] ^ f[1]));
            end
            chk("R2 flags held over branches", int'(flags), f);
        end

        // R4: signed compare, flags set to mislead
        write_flags(4'b0110);
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int r = 0; r < 8; r++) begin
                    branch(1, r, pick(i), pick(j), "R4 compare relation",
                           rel_exp(r, pick(i) == pick(j),
                                   $signed(pick(i)) < $signed(pick(j))));
                end
            end
        end
        chk("R4 compare leaves flags", int'(flags), 6);

        // R5: zero test and reserved source
        for (int i = 0; i < 6; i++) begin
            for (int r = 0; r < 8; r++) begin
                branch(2, r, pick(i), 16'h0000, "R5 zero test",
                       (r == 0) ? int'(pick(i) == 0) :
                       (r == 1) ? int'(pick(i) != 0) : 0);
                branch(3, r, pick(i), pick(i), "R5 reserved source", 0);
            end
        end

        // R6: valid low masks a true condition
        branch(1, 0, 16'h0003, 16'h0003, "R6 valid high", 1);
        @(negedge clk);
        br_valid = 1'b0;
        #1;
        chk("R6 valid low", int'(br_taken), 0);
        chk("R2 flags after all modes", int'(flags), 6);

        // R8: marker while idle
        @(negedge clk);
        loop_end = 1'b1;
        #1;
        chk("R8 idle marker", int'(loop_back), 0);
        @(negedge clk);
        loop_end = 1'b0;
        chk("R8 still idle", int'(rpt_active), 0);

        // R7, R8, R9: counts 0..6
        for (int n = 0; n < 7; n++) begin
            @(negedge clk);
            rpt_load  = 1'b1;
            rpt_count = CW'(n);
            #1;
            chk("R9 skip flag", int'(rpt_skip), int'(n == 0));
            @(negedge clk);
            rpt_load = 1'b0;
            chk("R9 active after load", int'(rpt_active), int'(n != 0));
            if (n != 0) begin
                run_loop(n, "R7 loop-back per pass", p);
                chk("R7 pass count", p, n);
            end
            chk("R8 cleared after loop", int'(rpt_active), 0);
        end

        // R10: load together with marker, then reload mid-loop
        @(negedge clk);
        rpt_load  = 1'b1;
        rpt_count = CW'(4);
        @(negedge clk);
        rpt_count = CW'(3);
        loop_end  = 1'b1;
        #1;
        chk("R10 no back on load+marker", int'(loop_back), 0);
        @(negedge clk);
        rpt_load = 1'b0;
        loop_end = 1'b0;
        run_loop(3, "R10 restarted count", p);
        chk("R10 passes after reload", p, 3);
        chk("R8 cleared after reload loop", int'(rpt_active), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule